// File: doc/BRIEF.md
# Scan Test Sequencer with Slow and At-Speed Capture

This block runs a single scan-test pattern through an internal chain of flip-flops, each of which has a multiplexed input. A pulse on the start input makes the block do four things in order. It loads a serial stimulus into the chain with scan enable held high. It then drops scan enable for a capture phase. After that it raises scan enable again and unloads the captured response, comparing each bit against a serial expected-response input. Finally it returns to idle and reports done. The chain and a small combinational cloud between its flops are included as the device under test.

Two capture variants are available, and the mode select chooses between them when the pattern starts. Slow stuck-at capture applies one capture pulse at the reduced shift rate. At-speed capture applies a launch pulse followed by a capture pulse on the very next functional clock, which targets transition and path-delay faults. The shift rate comes from a divider that emits one chain clock-enable every `DIV_N` functional cycles. While the response is unloaded, new stimulus bits enter the chain, so the unload of one pattern overlaps the load of the next. Any mismatch during unload sets a sticky fail flag, and the next accepted start clears it.

Top module: `scan_test_seq`

## Requirements
- R1: During and straight after reset, scan enable, chain clock-enable, busy, done and fail are all 0, and every chain flop, and with it the scan-out bit, is 0.
- R2: A start in idle is accepted. Busy is 1 from the next cycle until the run ends, and fail is 0 in that next cycle. A start while busy is ignored.
- R3: In the load and unload phases, the chain clock-enable pulses for one cycle every `DIV_N` clocks. The first pulse comes in the `DIV_N`-th cycle of the phase, and each phase has exactly `CHAIN_LEN` pulses.
- R4: On a pulse with scan enable 1, flop 0 takes the scan-in bit and flop i takes flop i-1. Scan-out is the last flop, flop `CHAIN_LEN-1`. Without a pulse the chain holds its value.
- R5: On a pulse with scan enable 0, flop i takes q[i-1] XOR (q[i] AND q[i+1]), with the indices taken modulo `CHAIN_LEN`.
- R6: In slow mode (mode input 0), scan enable is 0 for `DIV_N` cycles. Exactly one capture pulse occurs in that time, and it comes `DIV_N` cycles after the last load pulse.
- R7: In at-speed mode (mode input 1), scan enable is 0 for `DIV_N`+1 cycles. There are exactly two capture pulses: the first `DIV_N` cycles after the last load pulse, and the second on the next clock.
- R8: The mode is sampled when start is accepted, and changing the mode input during a run has no effect.
- R9: Scan enable never changes value in a cycle in which a chain clock-enable pulse is present. The first unload pulse comes `DIV_N` cycles after the last capture pulse.
- R10: On each unload pulse, if scan-out differs from the expected bit, fail is set. Fail stays set until the next accepted start. The expected bit is ignored in all other cycles.
- R11: The scan-in bits shifted in during unload stay in the chain and appear at scan-out during the next load.
- R12: Done is 1 for exactly one cycle, in the first idle cycle after the last unload pulse, and busy is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one pattern (accepted only when idle) |
| atspeed_i | input | 1 | Capture mode: 0 slow single pulse, 1 launch plus capture |
| scan_in_i | input | 1 | Serial stimulus bit |
| expect_i | input | 1 | Expected response bit for the current unload pulse |
| scan_en_o | output | 1 | Scan enable to the chain |
| chain_ce_o | output | 1 | Chain clock-enable pulse |
| scan_out_o | output | 1 | Last chain flop |
| busy_o | output | 1 | Pattern in progress |
| done_o | output | 1 | One-cycle pulse on return to idle |
| fail_o | output | 1 | Sticky mismatch flag |

## Verification
The same stimulus word is run through slow mode and then through at-speed mode. The cloud is applied once in the first case and twice in the second, so the two unloaded responses differ, and this separates a missing launch pulse from a correct capture. Runs with all-ones, all-zeros and mixed words check the shift and cloud paths under both heavy and sparse logic activity. One run injects a single wrong expected bit to show that fail becomes set and stays set, and the run after it shows that start clears the flag. A disturbed run toggles the mode input and pulses start in the middle of the run, and the capture-pulse count shows that neither has any effect.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE     = 3'd0,
    SQ_SHIFT    = 3'd1,
    SQ_CAPTURE1 = 3'd2,
    SQ_CAPTURE2 = 3'd3,
    SQ_UNLOAD   = 3'd4
  } sq_state_e;

  typedef enum logic {
    CAP_SLOW    = 1'b0,
    CAP_ATSPEED = 1'b1
  } cap_mode_e;

endpackage

// File: rtl/scan_rate_div.sv
module scan_rate_div #(
  parameter int DIV_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV_N - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i)             cnt_d = '0;
    else if (cnt_q == TOP) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = !clr_i && (cnt_q == TOP);

  // Slow-rate pulses are never adjacent (DIV_N >= 2)
  assert_tick_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/scan_chain_dut.sv
module scan_chain_dut #(
  parameter int CHAIN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic se_i,
  input  logic si_i,
  output logic so_o
);
  logic [CHAIN_LEN-1:0] q_q, q_d, shift_w, cloud_w;

  assign shift_w = {q_q[CHAIN_LEN-2:0], si_i};

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cloud
    localparam int PREV = (i + CHAIN_LEN - 1) % CHAIN_LEN;
    localparam int NEXT = (i + 1) % CHAIN_LEN;
    assign cloud_w[i] = q_q[PREV] ^ (q_q[i] & q_q[NEXT]);
  end

  always_comb begin
    if (!ce_i)     q_d = q_q;
    else if (se_i) q_d = shift_w;
    else           q_d = cloud_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign so_o = q_q[CHAIN_LEN-1];

  assert_shift_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && se_i) |=> (q_q[0] == $past(si_i)));

  assert_hold_without_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable(q_q));

endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic atspeed_i,
  input  logic tick_i,
  input  logic scan_out_i,
  input  logic expect_i,
  output logic scan_en_o,
  output logic chain_ce_o,
  output logic div_clr_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int BW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [BW-1:0] LAST = BW'(CHAIN_LEN - 1);

  sq_state_e state_q, state_d;
  cap_mode_e mode_q, mode_d;
  logic [BW-1:0] bit_q, bit_d;
  logic fail_q, fail_d, done_q, done_d;
  logic accept, serial_ph, last_bit;

  assign accept    = (state_q == SQ_IDLE) && start_i;
  assign serial_ph = (state_q == SQ_SHIFT) || (state_q == SQ_UNLOAD);
  assign last_bit  = (bit_q == LAST);

  always_comb begin
    chain_ce_o = 1'b0;
    unique case (state_q)
      SQ_SHIFT, SQ_UNLOAD, SQ_CAPTURE1: chain_ce_o = tick_i;
      SQ_CAPTURE2:                      chain_ce_o = 1'b1;
      default:                          chain_ce_o = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:     if (start_i) state_d = SQ_SHIFT;
      SQ_SHIFT:    if (tick_i && last_bit) state_d = SQ_CAPTURE1;
      SQ_CAPTURE1: if (tick_i)
                     state_d = (mode_q == CAP_ATSPEED) ? SQ_CAPTURE2 : SQ_UNLOAD;
      SQ_CAPTURE2: state_d = SQ_UNLOAD;
      SQ_UNLOAD:   if (tick_i && last_bit) state_d = SQ_IDLE;
      default:     state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    bit_d = bit_q;
    if (serial_ph && tick_i) bit_d = last_bit ? '0 : bit_q + 1'b1;
  end

  always_comb begin
    mode_d = mode_q;
    if (accept) mode_d = atspeed_i ? CAP_ATSPEED : CAP_SLOW;
  end

  always_comb begin
    fail_d = fail_q;
    if (accept) fail_d = 1'b0;
    else if ((state_q == SQ_UNLOAD) && tick_i && (scan_out_i != expect_i)) fail_d = 1'b1;
  end

  assign done_d = (state_q == SQ_UNLOAD) && tick_i && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mode_q  <= CAP_SLOW;
      bit_q   <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      bit_q   <= bit_d;
      fail_q  <= fail_d;
      done_q  <= done_d;
    end
  end

  assign scan_en_o = serial_ph;
  assign div_clr_o = (state_q == SQ_IDLE) || (state_q == SQ_CAPTURE2);
  assign busy_o    = (state_q != SQ_IDLE);
  assign done_o    = done_q;
  assign fail_o    = fail_q;

  assert_se_steady_on_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_ce_o |-> $stable(scan_en_o));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !fail_o));

  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !(start_i && !busy_o)) |=> fail_o);

  assert_launch_then_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CAPTURE2) |-> ($past(chain_ce_o) && !scan_en_o));

  assert_slow_single_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_ce_o && !scan_en_o && mode_q == CAP_SLOW) |=> scan_en_o);

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
  parameter int CHAIN_LEN = 8,
  parameter int DIV_N     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic atspeed_i,
  input  logic scan_in_i,
  input  logic expect_i,
  output logic scan_en_o,
  output logic chain_ce_o,
  output logic scan_out_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick, div_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  scan_rate_div #(.DIV_N(DIV_N)) i_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (div_clr),
    .tick_o (tick)
  );

  scan_seq_fsm #(.CHAIN_LEN(CHAIN_LEN)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .atspeed_i  (atspeed_i),
    .tick_i     (tick),
    .scan_out_i (scan_out_o),
    .expect_i   (expect_i),
    .scan_en_o  (scan_en_o),
    .chain_ce_o (chain_ce_o),
    .div_clr_o  (div_clr),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
  );

  scan_chain_dut #(.CHAIN_LEN(CHAIN_LEN)) i_chain (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ce_i  (chain_ce_o),
    .se_i  (scan_en_o),
    .si_i  (scan_in_i),
    .so_o  (scan_out_o)
  );

endmodule

// File: tb/test_scan_test_seq.sv
module test_scan_test_seq;
  localparam int N = 8;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, atspeed_i = 1'b0, scan_in_i = 1'b0, expect_i = 1'b0;
  logic scan_en_o, chain_ce_o, scan_out_o, busy_o, done_o, fail_o;

  always #4 clk = ~clk;

  scan_test_seq #(.CHAIN_LEN(N), .DIV_N(P)) i_scan_test_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .atspeed_i(atspeed_i),
    .scan_in_i(scan_in_i), .expect_i(expect_i), .scan_en_o(scan_en_o),
    .chain_ce_o(chain_ce_o), .scan_out_o(scan_out_o), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural reference
  bit m_busy = 0, m_done = 0, m_fail = 0, m_mode = 0;
  int m_t = 0;
  logic [N-1:0] m_chain = '0;
  int cap_n = 0, cap_consec = 0;
  bit prev_cap = 0;

  function automatic int total_len();
    return (2*N+1)*P + (m_mode ? 1 : 0);
  endfunction
  function automatic bit m_unload();
    return m_busy && (m_t >= (N+1)*P + (m_mode ? 1 : 0));
  endfunction
  function automatic bit m_se();
    if (!m_busy) return 0;
    return !(m_t >= N*P && m_t < (N+1)*P + (m_mode ? 1 : 0));
  endfunction
  function automatic bit m_ce();
    if (!m_busy) return 0;
    if (!m_mode || m_t < (N+1)*P) return (m_t % P) == P-1;
    if (m_t == (N+1)*P) return 1;
    return ((m_t - (N+1)*P - 1) % P) == P-1;
  endfunction
  function automatic logic [N-1:0] cloud(input logic [N-1:0] c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = c[(i+N-1)%N] ^ (c[i] & c[(i+1)%N]);
    return r;
  endfunction

  task automatic ck(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (t=%0d)", tag, what, act, exp, m_t);
    end
  endtask

  always @(negedge clk) begin
    bit e_se, e_ce, nd;
    string t_se, t_ce, t_so;
    e_se = m_se();
    e_ce = m_ce();
    if (!rst_n) begin
      t_se = "R1"; t_ce = "R1"; t_so = "R1";
    end else begin
      t_se = (m_busy && !e_se) ? (m_mode ? "R7" : "R6") : "R9";
      t_ce = (m_busy && m_t >= N*P && m_t <= (N+1)*P) ? (m_mode ? "R7" : "R6") : "R3";
      t_so = m_unload() ? "R5" : (m_busy ? "R11" : "R4");
    end
    ck(scan_en_o, e_se, t_se, "scan_en");
    ck(chain_ce_o, e_ce, t_ce, "chain_ce");
    ck(scan_out_o, m_chain[N-1], t_so, "scan_out");
    ck(busy_o, m_busy, rst_n ? "R2" : "R1", "busy");
    ck(done_o, m_done, rst_n ? "R12" : "R1", "done");
    ck(fail_o, m_fail, rst_n ? "R10" : "R1", "fail");
    if (chain_ce_o && !scan_en_o) begin
      cap_n++;
      if (prev_cap) cap_consec++;
      prev_cap = 1;
    end else prev_cap = 0;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_fail = 0; m_mode = 0; m_t = 0; m_chain = '0;
    end else begin
      nd = 0;
      if (m_busy) begin
        if (e_ce) begin
          if (e_se) begin
            if (m_unload() && (m_chain[N-1] != expect_i)) m_fail = 1;
            m_chain = {m_chain[N-2:0], scan_in_i};
          end else m_chain = cloud(m_chain);
        end
        m_t++;
        if (m_t == total_len()) begin m_busy = 0; nd = 1; end
      end else if (start_i) begin
        m_busy = 1; m_t = 0; m_mode = atspeed_i; m_fail = 0;
        cap_n = 0; cap_consec = 0; prev_cap = 0;
      end
      m_done = nd;
    end
  end

  task automatic run(input bit m, input logic [N-1:0] stim, input bit inject, input bit disturb);
    int k;
    bit injected;
    k = 0; injected = 0;
    @(posedge clk); #1;
    start_i = 1; atspeed_i = m;
    forever begin
      @(posedge clk); #1;
      start_i   = disturb && (k == 10 || k == 40);   // R2: ignored while busy
      atspeed_i = disturb ? ~m : m;                  // R8: ignored after start
      if (m_done) break;
      scan_in_i = stim[k % N];
      if (m_unload() && m_ce() && m_se()) begin
        expect_i = m_chain[N-1];
        if (inject && !injected) begin expect_i = ~m_chain[N-1]; injected = 1; end
      end else expect_i = ~m_chain[N-1];             // R10: ignored off-pulse
      k++;
    end
    start_i = 0;
    @(negedge clk); #1;
    ck(cap_n == (m ? 2 : 1), 1'b1, disturb ? "R8" : (m ? "R7" : "R6"), "capture pulse count");
    if (m) ck(cap_consec == 1, 1'b1, "R7", "launch/capture adjacent");
    if (inject) ck(fail_o, 1'b1, "R10", "fail after mismatch");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    ck(scan_en_o | chain_ce_o | busy_o | done_o | fail_o | scan_out_o, 1'b0, "R1", "reset outputs");
    rst_n = 1;
    repeat (4) @(posedge clk);
    run(0, 8'hA5, 0, 0);
    run(1, 8'hA5, 0, 0);
    run(0, 8'h3C, 1, 0);
    run(0, 8'hFF, 0, 0);
    ck(fail_o, 1'b0, "R10", "fail cleared by start");
    run(1, 8'hFF, 0, 1);
    run(0, 8'h00, 0, 1);
    run(1, 8'h96, 1, 0);
    run(1, 8'h5A, 0, 0);
    repeat (3) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R12 watchdog: actual no completion expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule